// File: doc/BRIEF.md
# Banked Memory Address Decoder

This block sits between a 16-bit processor bus and a set of byte-wide memory devices. The bus carries a 20-bit byte address, and its data path is split into two byte lanes. The low lane is D7-D0 and the high lane is D15-D8. The block is purely combinational. From the address and a memory/IO qualifier it forms eight active-low chip selects. Each select covers one 8K region inside the top 64K of the address space, F0000H-FFFFFH. From the read and write commands it forms the device strobes. There is one read strobe that both lanes share, and one write strobe per lane. Because each lane has its own write strobe, a byte write to one lane never disturbs the other lane. One region decoder is therefore enough, with no second decoder per lane.

The decoder only passes a write to a lane when that lane's enable is low. The low-lane enable is address bit 0, and the high-lane enable is a separate bus-high enable pin. A 16-bit write enables both lanes and drives both write strobes. During an I/O cycle every output stays inactive. If read and write are both asserted in the same cycle, the block blocks every strobe and raises an error flag. This way the read strobe and a write strobe are never low together.

Top module: `bank_mem_decoder`

## Requirements
- R1: With `mem_sel` = 1 and `addr[19:16]` = 4'hF, exactly one chip select is low. All eight chip selects are high for any other address, or when `mem_sel` = 0.
- R2: Inside the decoded span, the low chip select is `cs_n[addr[15:13]]`. Output 0 covers F0000H-F1FFFH, output 1 covers F2000H-F3FFFH, and so on up to output 7 at FE000H-FFFFFH.
- R3: When `mem_sel` = 0 (I/O cycle), every select and strobe is high and `cmd_clash` is 0, whatever the command and address pins are.
- R4: `wr_lo_stb_n` is low exactly when the cycle is a memory cycle inside the decoded span, `wr_cmd_n` = 0, `rd_cmd_n` = 1, and `addr[0]` = 0.
- R5: `wr_hi_stb_n` is low exactly when the cycle is a memory cycle inside the decoded span, `wr_cmd_n` = 0, `rd_cmd_n` = 1, and `bhe_n` = 0.
- R6: A 16-bit write (`addr[0]` = 0 and `bhe_n` = 0) drives both write strobes low in the same cycle. A byte write drives only its own lane's strobe low.
- R7: `rd_stb_n` is low exactly when the cycle is a memory cycle inside the decoded span, `rd_cmd_n` = 0, and `wr_cmd_n` = 1. The lane enables have no effect on it.
- R8: When `mem_sel` = 1, `rd_cmd_n` = 0 and `wr_cmd_n` = 0, all three strobes are high and `cmd_clash` is 1. The chip selects still decode per R1 and R2.
- R9: `rd_stb_n` is never low in the same cycle as either write strobe.
- R10: For a memory cycle outside F0000H-FFFFFH, no strobe goes low and every chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mem_sel | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| addr | input | 20 | Byte address; bit 0 is also the low-lane enable (active low) |
| bhe_n | input | 1 | High-lane enable, active low |
| rd_cmd_n | input | 1 | Read command, active low |
| wr_cmd_n | input | 1 | Write command, active low |
| cs_n | output | 8 | Region chip selects, active low, one per 8K |
| rd_stb_n | output | 1 | Shared read strobe for both lanes, active low |
| wr_lo_stb_n | output | 1 | Write strobe for the low lane, active low |
| wr_hi_stb_n | output | 1 | Write strobe for the high lane, active low |
| cmd_clash | output | 1 | High when read and write are both commanded in a memory cycle |

## Verification
The assertions assume the input pins have settled to known 0/1 values whenever the checker evaluates. They make no assumption about how the commands pair up, so clashing read and write, I/O cycles and out-of-span addresses are all legal inputs. The stimulus changes all inputs together, once per clock edge, and the outputs are compared half a period later. Besides directed cases, the stimulus sweeps all eight regions and every combination of commands and lane enables. It then uses pseudo-random addresses, weighted so that about half fall in the top 64K.

// File: rtl/bank_mem_decoder_pkg.sv
package bank_mem_decoder_pkg;
  localparam int unsigned DEF_ADDR_W = 20;
  localparam int unsigned DEF_GATE_W = 4;
  localparam int unsigned DEF_SEL_W  = 3;
  localparam int unsigned LANES      = 2;
  localparam int unsigned LANE_LO    = 0;
  localparam int unsigned LANE_HI    = 1;

  typedef struct packed {
    logic mem_cycle;
    logic rd_req;
    logic wr_req;
    logic clash;
  } bus_cmd_t;
endpackage

// File: rtl/bus_cmd_qualify.sv
module bus_cmd_qualify
  import bank_mem_decoder_pkg::*;
(
  input  logic     mem_sel,
  input  logic     rd_cmd_n,
  input  logic     wr_cmd_n,
  output bus_cmd_t cmd
);
  logic rd_raw, wr_raw, both;

  always_comb begin
    rd_raw        = ~rd_cmd_n;
    wr_raw        = ~wr_cmd_n;
    both          = rd_raw & wr_raw;
    cmd.mem_cycle = mem_sel;
    cmd.clash     = mem_sel & both;
    // a clashing pair is dropped entirely so neither strobe can fire
    cmd.rd_req    = mem_sel & rd_raw & ~both;
    cmd.wr_req    = mem_sel & wr_raw & ~both;
  end
endmodule

// File: rtl/mem_region_decode.sv
module mem_region_decode #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned GATE_W = 4,
  parameter int unsigned SEL_W  = 3,
  localparam int unsigned N_CS  = 1 << SEL_W
) (
  input  logic              mem_cycle,
  input  logic [ADDR_W-1:0] addr,
  output logic              span_hit,
  output logic [N_CS-1:0]   cs_n
);
  localparam int unsigned SEL_TOP = ADDR_W - GATE_W - 1;

  logic [GATE_W-1:0] gate_bits;
  logic [SEL_W-1:0]  region_idx;
  logic [ADDR_W-GATE_W-SEL_W-1:0] unused_addr_low;

  assign gate_bits       = addr[ADDR_W-1 -: GATE_W];
  assign region_idx      = addr[SEL_TOP -: SEL_W];
  assign unused_addr_low = addr[ADDR_W-GATE_W-SEL_W-1:0];
  assign span_hit        = mem_cycle & (&gate_bits);

  for (genvar g = 0; g < N_CS; g++) begin : g_region
    assign cs_n[g] = ~(span_hit && (region_idx == SEL_W'(g)));
  end
endmodule

// File: rtl/lane_strobe_gen.sv
module lane_strobe_gen
  import bank_mem_decoder_pkg::*;
#(
  parameter int unsigned N_LANE = LANES
) (
  input  logic              span_hit,
  input  bus_cmd_t          cmd,
  input  logic [N_LANE-1:0] lane_en_n,
  output logic [N_LANE-1:0] wr_lane_n,
  output logic              rd_n
);
  logic unused_cmd_bits;
  assign unused_cmd_bits = cmd.mem_cycle ^ cmd.clash;

  // one read strobe serves every lane; the data bus takes both bytes
  assign rd_n = ~(span_hit & cmd.rd_req);

  for (genvar l = 0; l < N_LANE; l++) begin : g_lane
    assign wr_lane_n[l] = ~(span_hit & cmd.wr_req & ~lane_en_n[l]);
  end
endmodule

// File: rtl/bank_mem_decoder.sv
module bank_mem_decoder
  import bank_mem_decoder_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned GATE_W = DEF_GATE_W,
  parameter int unsigned SEL_W  = DEF_SEL_W,
  localparam int unsigned N_CS  = 1 << SEL_W
) (
  input  logic              mem_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              bhe_n,
  input  logic              rd_cmd_n,
  input  logic              wr_cmd_n,
  output logic [N_CS-1:0]   cs_n,
  output logic              rd_stb_n,
  output logic              wr_lo_stb_n,
  output logic              wr_hi_stb_n,
  output logic              cmd_clash
);
  bus_cmd_t          cmd;
  logic              span_hit;
  logic [LANES-1:0]  lane_en_n;
  logic [LANES-1:0]  wr_lane_n;

  assign lane_en_n[LANE_LO] = addr[0];
  assign lane_en_n[LANE_HI] = bhe_n;

  bus_cmd_qualify u_cmd (
    .mem_sel  (mem_sel),
    .rd_cmd_n (rd_cmd_n),
    .wr_cmd_n (wr_cmd_n),
    .cmd      (cmd)
  );

  mem_region_decode #(
    .ADDR_W (ADDR_W),
    .GATE_W (GATE_W),
    .SEL_W  (SEL_W)
  ) u_region (
    .mem_cycle (cmd.mem_cycle),
    .addr      (addr),
    .span_hit  (span_hit),
    .cs_n      (cs_n)
  );

  lane_strobe_gen #(
    .N_LANE (LANES)
  ) u_strobe (
    .span_hit  (span_hit),
    .cmd       (cmd),
    .lane_en_n (lane_en_n),
    .wr_lane_n (wr_lane_n),
    .rd_n      (rd_stb_n)
  );

  assign wr_lo_stb_n = wr_lane_n[LANE_LO];
  assign wr_hi_stb_n = wr_lane_n[LANE_HI];
  assign cmd_clash   = cmd.clash;
endmodule

// File: rtl/bank_mem_decoder_chk.sv
module bank_mem_decoder_chk #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned GATE_W = 4,
  parameter int unsigned SEL_W  = 3,
  localparam int unsigned N_CS  = 1 << SEL_W
) (
  input logic              mem_sel,
  input logic [ADDR_W-1:0] addr,
  input logic              bhe_n,
  input logic              rd_cmd_n,
  input logic              wr_cmd_n,
  input logic [N_CS-1:0]   cs_n,
  input logic              rd_stb_n,
  input logic              wr_lo_stb_n,
  input logic              wr_hi_stb_n,
  input logic              cmd_clash
);
  logic in_top;
  logic any_strobe;
  assign in_top     = &addr[ADDR_W-1 -: GATE_W];
  assign any_strobe = ~rd_stb_n | ~wr_lo_stb_n | ~wr_hi_stb_n;

  always_comb begin
    // R1
    one_select_chk: assert ($countones(~cs_n) == ((mem_sel && in_top) ? 1 : 0));
    // R2
    region_pick_chk: assert (!(mem_sel && in_top) || !cs_n[addr[ADDR_W-GATE_W-1 -: SEL_W]]);
    // R3
    io_quiet_chk: assert (mem_sel || (&cs_n && !any_strobe && !cmd_clash));
    // R4
    lo_write_chk: assert (wr_lo_stb_n || (mem_sel && in_top && !wr_cmd_n && rd_cmd_n && !addr[0]));
    // R5
    hi_write_chk: assert (wr_hi_stb_n || (mem_sel && in_top && !wr_cmd_n && rd_cmd_n && !bhe_n));
    // R7
    read_gate_chk: assert (rd_stb_n || (mem_sel && in_top && !rd_cmd_n && wr_cmd_n));
    // R8
    clash_chk: assert (!(mem_sel && !rd_cmd_n && !wr_cmd_n) || (cmd_clash && !any_strobe));
    // R9
    no_rw_overlap_chk: assert (rd_stb_n || (wr_lo_stb_n && wr_hi_stb_n));
    // R10
    out_of_span_chk: assert (in_top || (!any_strobe && &cs_n));
  end
endmodule

bind bank_mem_decoder bank_mem_decoder_chk #(
  .ADDR_W (ADDR_W),
  .GATE_W (GATE_W),
  .SEL_W  (SEL_W)
) i_chk (
  .mem_sel     (mem_sel),
  .addr        (addr),
  .bhe_n       (bhe_n),
  .rd_cmd_n    (rd_cmd_n),
  .wr_cmd_n    (wr_cmd_n),
  .cs_n        (cs_n),
  .rd_stb_n    (rd_stb_n),
  .wr_lo_stb_n (wr_lo_stb_n),
  .wr_hi_stb_n (wr_hi_stb_n),
  .cmd_clash   (cmd_clash)
);

// File: tb/test_bank_mem_decoder.sv
module test_bank_mem_decoder;
  localparam int unsigned WATCHDOG = 20000;

  typedef struct packed {
    logic [7:0] cs_n;
    logic       rd;
    logic       wlo;
    logic       whi;
    logic       err;
  } outv_t;

  typedef struct {
    outv_t exp;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        mem_sel  = 1'b0;
  logic [19:0] addr     = '0;
  logic        bhe_n    = 1'b1;
  logic        rd_cmd_n = 1'b1;
  logic        wr_cmd_n = 1'b1;
  logic [7:0]  cs_n;
  logic        rd_stb_n, wr_lo_stb_n, wr_hi_stb_n, cmd_clash;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  item_t sb[$];

  bank_mem_decoder i_bank_mem_decoder (
    .mem_sel     (mem_sel),
    .addr        (addr),
    .bhe_n       (bhe_n),
    .rd_cmd_n    (rd_cmd_n),
    .wr_cmd_n    (wr_cmd_n),
    .cs_n        (cs_n),
    .rd_stb_n    (rd_stb_n),
    .wr_lo_stb_n (wr_lo_stb_n),
    .wr_hi_stb_n (wr_hi_stb_n),
    .cmd_clash   (cmd_clash)
  );

  function automatic outv_t model(logic m, logic [19:0] a, logic bh, logic r, logic w);
    outv_t o;
    logic hit;
    hit    = m && (a[19:16] == 4'hF);              // R1 R10
    o.cs_n = 8'hFF;
    if (hit) o.cs_n[a[15:13]] = 1'b0;              // R2
    o.err  = m && !r && !w;                        // R8
    o.rd   = !(hit && !r && w);                    // R7
    o.wlo  = !(hit && !w && r && !a[0]);           // R4
    o.whi  = !(hit && !w && r && !bh);             // R5
    return o;
  endfunction

  task automatic drive(logic m, logic [19:0] a, logic bh, logic r, logic w, string tag);
    item_t it;
    @(posedge clk);
    mem_sel = m; addr = a; bhe_n = bh; rd_cmd_n = r; wr_cmd_n = w;
    it.exp = model(m, a, bh, r, w);
    it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: compares half a period after each drive
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      outv_t act;
      it  = sb.pop_front();
      act = '{cs_n, rd_stb_n, wr_lo_stb_n, wr_hi_stb_n, cmd_clash};
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s addr=%h mem=%b bhe_n=%b rd=%b wr=%b actual=%h expected=%h",
                 it.tag, addr, mem_sel, bhe_n, rd_cmd_n, wr_cmd_n, act, it.exp);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=expired expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    // reset/idle state: I/O qualifier, no commands (R3)
    drive(1'b0, 20'h00000, 1'b1, 1'b1, 1'b1, "R3 idle");
    // every region, read and word write (R1 R2 R7 R6)
    for (int i = 0; i < 8; i++) begin
      drive(1'b1, 20'hF0000 | (20'(i) << 13) | 20'h0123, 1'b0, 1'b0, 1'b1, "R1 R2 R7 read");
      drive(1'b1, 20'hF0000 | (20'(i) << 13) | 20'h1FFE, 1'b0, 1'b1, 1'b0, "R2 R6 word write");
    end
    // region edges
    drive(1'b1, 20'hF1FFF, 1'b1, 1'b0, 1'b1, "R2 edge F1FFF");
    drive(1'b1, 20'hF2000, 1'b1, 1'b0, 1'b1, "R2 edge F2000");
    drive(1'b1, 20'hFFFFF, 1'b0, 1'b0, 1'b1, "R2 R7 top");
    // byte writes per lane
    drive(1'b1, 20'hF4000, 1'b1, 1'b1, 1'b0, "R4 R6 low byte");
    drive(1'b1, 20'hF4001, 1'b0, 1'b1, 1'b0, "R5 R6 high byte");
    drive(1'b1, 20'hF4001, 1'b1, 1'b1, 1'b0, "R4 R5 no lane");
    drive(1'b1, 20'hF6001, 1'b1, 1'b0, 1'b1, "R7 read no lane");
    // clash
    drive(1'b1, 20'hFA000, 1'b0, 1'b0, 1'b0, "R8 R9 clash");
    drive(1'b1, 20'h12340, 1'b0, 1'b0, 1'b0, "R8 clash out of span");
    // I/O cycles with every command
    drive(1'b0, 20'hF0000, 1'b0, 1'b0, 1'b1, "R3 io read");
    drive(1'b0, 20'hFC000, 1'b0, 1'b1, 1'b0, "R3 io write");
    drive(1'b0, 20'hFC000, 1'b0, 1'b0, 1'b0, "R3 io clash");
    // outside the span
    drive(1'b1, 20'hEFFFF, 1'b0, 1'b0, 1'b1, "R10 EFFFF read");
    drive(1'b1, 20'h7F000, 1'b0, 1'b1, 1'b0, "R10 7F000 write");
    drive(1'b1, 20'h00000, 1'b0, 1'b1, 1'b0, "R10 zero write");
    // exhaustive command x lane sweep inside and outside the span
    for (int k = 0; k < 32; k++) begin
      drive(1'b1, (k[4] ? 20'hF8000 : 20'hE8000) | 20'(k[0]), k[1], k[2], k[3], "R4 R5 R7 R9 sweep");
    end
    // pseudo-random mix
    for (int k = 0; k < 300; k++) begin
      logic [19:0] a;
      logic [3:0]  b;
      a = 20'($urandom);
      b = 4'($urandom);
      if (b[3]) a[19:16] = 4'hF;
      drive(b[0] | b[1], a, b[2], 1'($urandom), 1'($urandom), "R1 R2 R3 R9 R10 mix");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule